// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block watches the write port of a flash device's host interface. It acts only on writes whose word address lands in one of two boot-command windows. Such a write is taken as a one-word command. A small state machine then turns these commands into strobes for the rest of the device:

- a warm-reset strobe;
- a page-load request to the array reader, followed by an update of the page address register;
- a three-word write burst into the boot buffer that publishes identity and protection data.

The page-load command takes two writes. The first write arms the sequencer. The next write in a window always disarms it. That second write starts a fetch only when it carries zero.

The state machine has five states:

- `ST_IDLE` waits for a first-cycle command.
- `ST_ARMED` waits for the second cycle of a load.
- `ST_ID_W0`, `ST_ID_W1` and `ST_ID_W2` each drive one boot-buffer word.

Its transitions are:

- "arm": `ST_IDLE` to `ST_ARMED` on 0x00E0.
- "fire or drop": `ST_ARMED` to `ST_IDLE` on any window write.
- "identify": `ST_IDLE` to `ST_ID_W0` on 0x0090.
- "step": `ST_ID_W0` to `ST_ID_W1` to `ST_ID_W2`, one per cycle.
- "finish": `ST_ID_W2` to `ST_IDLE`.
- "stay": `ST_IDLE` to `ST_IDLE` on 0x00F0 (with the reset strobe) and on any other value.

An asynchronous reset forces `ST_IDLE` from any state.

Top module: `bootseq_boot_cmd`

## Requirements
- R1: After reset all outputs are low and the sequencer is not armed: a zero write as the first window write after reset raises no load request.
- R2: Only writes at word addresses 0x0000 to 0x01FF or 0x8000 to 0x800F are commands. Writes elsewhere change no output and no state.
- R3: A window write of 0x00F0 while not armed raises `warm_rst_o` for exactly the one cycle after the write.
- R4: After a window write of 0x00E0, the next window write of 0x0000 raises `load_req_o` for one cycle, in the cycle after that write, with `load_count_o` equal to 4.
- R5: In the armed state, any window write other than 0x0000 (0x00F0 included) disarms the sequencer and raises no strobe. A later 0x0000 write then starts no load.
- R6: `load_sector_o` = (block_eff × 64 + page[7:2]) × 4 + page[1:0]. Here block_eff is `blk_idx_i` ORed with `density_mask_i` when `blk_upper_i` is 1, and plain `blk_idx_i` otherwise. The page, block and mask values are those present with the second-cycle write.
- R7: With each load request, `page_upd_o` is 1 and `page_next_o` = (page + 4) mod 256.
- R8: A window write of 0x0090 while not armed produces boot-buffer writes in the three following cycles, in this order:
  - word 0 = {8'h00, `mfr_id_i`};
  - word 1 = {8'h00, `dev_id_i`};
  - word 2 = {8'h00, `wp_low_i`}.
  `bb_we_o` is then low.
- R9: Any value other than 0x00F0, 0x00E0 or 0x0090 as a first-cycle command raises no strobe and does not arm.
- R10: Window writes that arrive during the three identification cycles are dropped.
- R11: Asserting reset while armed cancels the pending second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 16 | Word address of the host write |
| wr_data_i | input | 16 | Host write data |
| page_reg_i | input | 8 | Page address register (sector-in-page in bits 1:0) |
| blk_idx_i | input | 12 | Block address field |
| blk_upper_i | input | 1 | Selects the upper die: OR the density mask into the block |
| density_mask_i | input | 16 | Mask ORed into the block index for the upper die |
| mfr_id_i | input | 8 | Manufacturer identity byte |
| dev_id_i | input | 8 | Device identity byte |
| wp_low_i | input | 8 | Low byte of write-protect status |
| warm_rst_o | output | 1 | One-cycle warm-reset strobe |
| load_req_o | output | 1 | One-cycle page-load request |
| load_sector_o | output | 24 | First sector of the requested load |
| load_count_o | output | 3 | Sectors to load (4 while requesting) |
| page_upd_o | output | 1 | Page register update strobe |
| page_next_o | output | 8 | New page register value |
| bb_we_o | output | 1 | Boot-buffer write enable |
| bb_addr_o | output | 2 | Boot-buffer word index |
| bb_wdata_o | output | 16 | Boot-buffer write data |

## Verification
The assertions assume three things about the inputs:

- Page, block, mask and identity inputs are held stable around the write that uses them.
- At most one host write is presented per cycle.
- `wr_en_i` is low while reset is asserted, so the first cycle after reset has no write to look back on.

The stimulus drives every input on the falling edge and holds it for a full cycle. It changes the page and block values only between writes, and it keeps `wr_en_i` low during and just after each reset.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ID_W0,
        ST_ID_W1,
        ST_ID_W2
    } seq_state_t;

    localparam logic [15:0] OP_WARM_RST = 16'h00F0;
    localparam logic [15:0] OP_LOAD_ARM = 16'h00E0;
    localparam logic [15:0] OP_READ_ID  = 16'h0090;
    localparam logic [15:0] OP_LOAD_GO  = 16'h0000;

endpackage

// File: rtl/bootseq_win_dec.sv
module bootseq_win_dec #(
    parameter int AW       = 16,
    parameter int LO_BASE  = 'h0000,
    parameter int LO_WORDS = 'h0200,
    parameter int HI_BASE  = 'h8000,
    parameter int HI_WORDS = 'h0010
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o
);
    localparam int NWIN = 2;

    logic [NWIN-1:0] win_hit;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam int BASE  = (w == 0) ? LO_BASE  : HI_BASE;
        localparam int WORDS = (w == 0) ? LO_WORDS : HI_WORDS;
        logic [AW-1:0] offs;
        assign offs       = addr_i - AW'(BASE);
        assign win_hit[w] = ({1'b0, offs} < (AW+1)'(WORDS));
    end

    assign hit_o = |win_hit;

endmodule

// File: rtl/bootseq_sector.sv
module bootseq_sector #(
    parameter int BLK_W       = 16,
    parameter int BLK_FIELD_W = 12,
    parameter int SIP_W       = 2,
    parameter int PPB_LOG     = 6,
    localparam int PAGE_W     = SIP_W + PPB_LOG,
    localparam int LIN_W      = BLK_W + PPB_LOG,
    localparam int SEC_W      = BLK_W + PAGE_W
) (
    input  logic [PAGE_W-1:0]      page_i,
    input  logic [BLK_FIELD_W-1:0] blk_idx_i,
    input  logic                   blk_upper_i,
    input  logic [BLK_W-1:0]       dmask_i,
    output logic [SEC_W-1:0]       sector_o
);
    logic [BLK_W-1:0] blk_eff;
    logic [LIN_W-1:0] page_lin;

    always_comb begin
        blk_eff  = BLK_W'(blk_idx_i) | (blk_upper_i ? dmask_i : '0);
        page_lin = {blk_eff, {PPB_LOG{1'b0}}} + LIN_W'(page_i[PAGE_W-1:SIP_W]);
        sector_o = {page_lin, {SIP_W{1'b0}}} + SEC_W'(page_i[SIP_W-1:0]);
    end

endmodule

// File: rtl/bootseq_id_words.sv
module bootseq_id_words #(
    parameter int DW   = 16,
    parameter int ID_W = 8
) (
    input  logic [1:0]      idx_i,
    input  logic [ID_W-1:0] mfr_i,
    input  logic [ID_W-1:0] dev_i,
    input  logic [ID_W-1:0] wp_i,
    output logic [DW-1:0]   word_o
);
    always_comb begin
        unique case (idx_i)
            2'd0:    word_o = DW'(mfr_i);
            2'd1:    word_o = DW'(dev_i);
            2'd2:    word_o = DW'(wp_i);
            default: word_o = '0;
        endcase
    end

endmodule

// File: rtl/bootseq_boot_cmd.sv
module bootseq_boot_cmd
    import bootseq_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int BLK_W       = 16,
    parameter int BLK_FIELD_W = 12,
    parameter int SIP_W       = 2,
    parameter int PPB_LOG     = 6,
    parameter int ID_W        = 8,
    localparam int PAGE_W     = SIP_W + PPB_LOG,
    localparam int SEC_W      = BLK_W + PAGE_W,
    localparam int CNT_W      = SIP_W + 1,
    localparam int SECS_PG    = 1 << SIP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [AW-1:0]          wr_addr_i,
    input  logic [DW-1:0]          wr_data_i,
    input  logic [PAGE_W-1:0]      page_reg_i,
    input  logic [BLK_FIELD_W-1:0] blk_idx_i,
    input  logic                   blk_upper_i,
    input  logic [BLK_W-1:0]       density_mask_i,
    input  logic [ID_W-1:0]        mfr_id_i,
    input  logic [ID_W-1:0]        dev_id_i,
    input  logic [ID_W-1:0]        wp_low_i,
    output logic                   warm_rst_o,
    output logic                   load_req_o,
    output logic [SEC_W-1:0]       load_sector_o,
    output logic [CNT_W-1:0]       load_count_o,
    output logic                   page_upd_o,
    output logic [PAGE_W-1:0]      page_next_o,
    output logic                   bb_we_o,
    output logic [1:0]             bb_addr_o,
    output logic [DW-1:0]          bb_wdata_o
);
    seq_state_t state, nxt;

    logic             win_hit;
    logic             cmd_wr;
    logic             fire_rst;
    logic             fire_load;
    logic [SEC_W-1:0] sector_calc;
    logic [1:0]       id_idx;
    logic             id_active;
    logic [DW-1:0]    id_word;

    bootseq_win_dec #(.AW(AW)) u_win (
        .addr_i (wr_addr_i),
        .hit_o  (win_hit)
    );

    bootseq_sector #(
        .BLK_W       (BLK_W),
        .BLK_FIELD_W (BLK_FIELD_W),
        .SIP_W       (SIP_W),
        .PPB_LOG     (PPB_LOG)
    ) u_sec (
        .page_i      (page_reg_i),
        .blk_idx_i   (blk_idx_i),
        .blk_upper_i (blk_upper_i),
        .dmask_i     (density_mask_i),
        .sector_o    (sector_calc)
    );

    bootseq_id_words #(.DW(DW), .ID_W(ID_W)) u_id (
        .idx_i  (id_idx),
        .mfr_i  (mfr_id_i),
        .dev_i  (dev_id_i),
        .wp_i   (wp_low_i),
        .word_o (id_word)
    );

    assign cmd_wr = wr_en_i && win_hit;

    // next-state logic
    always_comb begin
        nxt       = state;
        fire_rst  = 1'b0;
        fire_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    if (wr_data_i == OP_WARM_RST) begin
                        fire_rst = 1'b1;
                    end else if (wr_data_i == OP_LOAD_ARM) begin
                        nxt = ST_ARMED;
                    end else if (wr_data_i == OP_READ_ID) begin
                        nxt = ST_ID_W0;
                    end
                end
            end
            ST_ARMED: begin
                if (cmd_wr) begin
                    nxt       = ST_IDLE;
                    fire_load = (wr_data_i == OP_LOAD_GO);
                end
            end
            ST_ID_W0: nxt = ST_ID_W1;
            ST_ID_W1: nxt = ST_ID_W2;
            ST_ID_W2: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        id_active = 1'b1;
        id_idx    = 2'd0;
        unique case (nxt)
            ST_ID_W0: id_idx = 2'd0;
            ST_ID_W1: id_idx = 2'd1;
            ST_ID_W2: id_idx = 2'd2;
            default:  id_active = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_rst_o    <= 1'b0;
            load_req_o    <= 1'b0;
            load_sector_o <= '0;
            load_count_o  <= '0;
            page_upd_o    <= 1'b0;
            page_next_o   <= '0;
            bb_we_o       <= 1'b0;
            bb_addr_o     <= '0;
            bb_wdata_o    <= '0;
        end else begin
            warm_rst_o    <= fire_rst;
            load_req_o    <= fire_load;
            page_upd_o    <= fire_load;
            load_sector_o <= fire_load ? sector_calc : '0;
            load_count_o  <= fire_load ? CNT_W'(SECS_PG) : '0;
            page_next_o   <= fire_load ? page_reg_i + PAGE_W'(SECS_PG) : '0;
            bb_we_o       <= id_active;
            bb_addr_o     <= id_active ? id_idx : '0;
            bb_wdata_o    <= id_active ? id_word : '0;
        end
    end

endmodule

// File: rtl/bootseq_boot_cmd_chk.sv
module bootseq_boot_cmd_chk #(
    parameter int DW     = 16,
    parameter int SIP_W  = 2,
    parameter int PAGE_W = 8,
    parameter int SEC_W  = 24,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [DW-1:0]     wr_data_i,
    input logic [PAGE_W-1:0] page_reg_i,
    input logic              warm_rst_o,
    input logic              load_req_o,
    input logic [SEC_W-1:0]  load_sector_o,
    input logic [CNT_W-1:0]  load_count_o,
    input logic [PAGE_W-1:0] page_next_o,
    input logic              bb_we_o,
    input logic [1:0]        bb_addr_o
);
    AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |-> ($past(wr_en_i) && $past(wr_data_i) == 16'h00F0)); // R3

    AST_LOAD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> ($past(wr_en_i) && $past(wr_data_i) == 16'h0000)); // R4

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |=> !load_req_o); // R4

    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> (load_count_o == CNT_W'(1 << SIP_W))); // R4

    AST_SECTOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> (load_sector_o[SIP_W-1:0] == $past(page_reg_i[SIP_W-1:0]))); // R6

    AST_PAGE_STEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_req_o |-> (page_next_o[SIP_W-1:0] == $past(page_reg_i[SIP_W-1:0]))); // R7

    AST_ID_W0_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_we_o && bb_addr_o == 2'd0) |=> (bb_we_o && bb_addr_o == 2'd1)); // R8

    AST_ID_W1_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_we_o && bb_addr_o == 2'd1) |=> (bb_we_o && bb_addr_o == 2'd2)); // R8

    AST_ID_W2_END: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_we_o && bb_addr_o == 2'd2) |=> !bb_we_o); // R8

    AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bb_we_o |-> (bb_addr_o != 2'd3)); // R8

endmodule

bind bootseq_boot_cmd bootseq_boot_cmd_chk #(
    .DW     (DW),
    .SIP_W  (SIP_W),
    .PAGE_W (PAGE_W),
    .SEC_W  (SEC_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .page_reg_i    (page_reg_i),
    .warm_rst_o    (warm_rst_o),
    .load_req_o    (load_req_o),
    .load_sector_o (load_sector_o),
    .load_count_o  (load_count_o),
    .page_next_o   (page_next_o),
    .bb_we_o       (bb_we_o),
    .bb_addr_o     (bb_addr_o)
);

// File: tb/test_bootseq_boot_cmd.sv
module test_bootseq_boot_cmd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  page = '0;
    logic [11:0] blk_idx = '0;
    logic        blk_upper = 1'b0;
    logic [15:0] dmask = 16'h1000;
    logic [7:0]  mfr = 8'hEC;
    logic [7:0]  dev = 8'h40;
    logic [7:0]  wp = 8'h34;

    logic        warm_rst, load_req, page_upd, bb_we;
    logic [23:0] load_sector;
    logic [2:0]  load_count;
    logic [7:0]  page_next;
    logic [1:0]  bb_addr;
    logic [15:0] bb_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bootseq_boot_cmd i_bootseq_boot_cmd (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en_i        (wr_en),
        .wr_addr_i      (wr_addr),
        .wr_data_i      (wr_data),
        .page_reg_i     (page),
        .blk_idx_i      (blk_idx),
        .blk_upper_i    (blk_upper),
        .density_mask_i (dmask),
        .mfr_id_i       (mfr),
        .dev_id_i       (dev),
        .wp_low_i       (wp),
        .warm_rst_o     (warm_rst),
        .load_req_o     (load_req),
        .load_sector_o  (load_sector),
        .load_count_o   (load_count),
        .page_upd_o     (page_upd),
        .page_next_o    (page_next),
        .bb_we_o        (bb_we),
        .bb_addr_o      (bb_addr),
        .bb_wdata_o     (bb_wdata)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  pg;
        logic [15:0] blk;     // bit 15 = upper die, bits 11:0 = index
        logic        e_rst;
        logic        e_load;
        logic [23:0] e_sec;
        logic [7:0]  e_pn;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0010, 16'h00E0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R4 arm
        '{16'h01FF, 16'h0000, 8'h05, 16'h0003, 1'b0, 1'b1, 24'h000305, 8'h09}, // R4 R6 R7
        '{16'h8000, 16'h00F0, 8'h00, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'h00}, // R3
        '{16'h800F, 16'h00E0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R4 arm high window
        '{16'h8004, 16'h0000, 8'hFE, 16'h8002, 1'b0, 1'b1, 24'h1002FE, 8'h02}, // R6 mask, R7 wrap
        '{16'h0000, 16'h00E0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R5 arm
        '{16'h0001, 16'h0001, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R5 nonzero disarms
        '{16'h0002, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R5 no load after
        '{16'h0003, 16'h1234, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R9 unknown
        '{16'h0004, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R9 not armed
        '{16'h0200, 16'h00E0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R2 outside
        '{16'h0005, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R2 not armed
        '{16'h8010, 16'h00F0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R2 above high
        '{16'h7FFF, 16'h00F0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R2 below high
        '{16'h0100, 16'h00E0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R4 arm
        '{16'h0100, 16'h00F0, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}, // R5 F0 while armed
        '{16'h0100, 16'h0000, 8'h00, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'h00}  // R5 stays disarmed
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 warm_rst", 32'(warm_rst), 32'd0);
        chk("R1 load_req", 32'(load_req), 32'd0);
        chk("R1 bb_we", 32'(bb_we), 32'd0);
        chk("R1 page_upd", 32'(page_upd), 32'd0);
        wr(16'h0000, 16'h0000);
        chk("R1 no load after reset", 32'(load_req), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            page      = VECS[i].pg;
            blk_idx   = VECS[i].blk[11:0];
            blk_upper = VECS[i].blk[15];
            wr(VECS[i].addr, VECS[i].data);
            chk($sformatf("vec%0d R3 warm_rst", i), 32'(warm_rst), 32'(VECS[i].e_rst));
            chk($sformatf("vec%0d R4 load_req", i), 32'(load_req), 32'(VECS[i].e_load));
            chk($sformatf("vec%0d R2 bb_we", i), 32'(bb_we), 32'd0);
            if (VECS[i].e_load) begin
                chk($sformatf("vec%0d R4 count", i), 32'(load_count), 32'd4);
                chk($sformatf("vec%0d R6 sector", i), 32'(load_sector), 32'(VECS[i].e_sec));
                chk($sformatf("vec%0d R7 page_upd", i), 32'(page_upd), 32'd1);
                chk($sformatf("vec%0d R7 page_next", i), 32'(page_next), 32'(VECS[i].e_pn));
            end
        end

        // R3 strobe is one cycle wide
        wr(16'h0080, 16'h00F0);
        chk("R3 strobe", 32'(warm_rst), 32'd1);
        @(negedge clk);
        chk("R3 strobe ends", 32'(warm_rst), 32'd0);

        // R8 identification burst through the high window
        wr(16'h8008, 16'h0090);
        chk("R8 w0 we", 32'(bb_we), 32'd1);
        chk("R8 w0 addr", 32'(bb_addr), 32'd0);
        chk("R8 w0 data", 32'(bb_wdata), 32'h00EC);
        @(negedge clk);
        chk("R8 w1 addr", 32'(bb_addr), 32'd1);
        chk("R8 w1 data", 32'(bb_wdata), 32'h0040);
        @(negedge clk);
        chk("R8 w2 addr", 32'(bb_addr), 32'd2);
        chk("R8 w2 data", 32'(bb_wdata), 32'h0034);
        @(negedge clk);
        chk("R8 done", 32'(bb_we), 32'd0);

        // R10 writes during identification are dropped
        wr(16'h0000, 16'h0090);
        wr(16'h0000, 16'h00E0);
        wr(16'h0000, 16'h00F0);
        chk("R10 no reset in burst", 32'(warm_rst), 32'd0);
        @(negedge clk);
        wr(16'h0000, 16'h0000);
        chk("R10 arm dropped", 32'(load_req), 32'd0);

        // R11 reset cancels armed state
        wr(16'h0000, 16'h00E0);
        do_reset();
        wr(16'h0000, 16'h0000);
        chk("R11 no load after reset", 32'(load_req), 32'd0);

        // R4 back-to-back load still works after everything
        page      = 8'h3C;
        blk_idx   = 12'h001;
        blk_upper = 1'b0;
        wr(16'h0000, 16'h00E0);
        wr(16'h01F0, 16'h0000);
        chk("R4 final load", 32'(load_req), 32'd1);
        chk("R6 final sector", 32'(load_sector), 32'h00013C);
        chk("R7 final page", 32'(page_next), 32'h40);
        @(negedge clk);
        chk("R4 load ends", 32'(load_req), 32'd0);

        finish_run();
    end

endmodule